// File: doc/BRIEF.md
# Unrolled Copy Instruction Generator

This block lets a CPU move a run of bytes from its own address space into a fixed peripheral data port without a DMA engine. Software first sets the peripheral's destination pointer itself. It then programs a 16-bit length value and a 16-bit source pointer into four byte registers and stores to one of two trigger registers. From the next instruction fetch onwards, the block answers every program-window read with bytes it generates on the fly. For each byte to be moved it supplies one absolute load from the current source address and one absolute store to the chosen port. After the last pair it supplies an absolute jump back to where the CPU would have continued.

Because the CPU itself runs this straight-line code, the transfer stays interruptible at every instruction boundary. Bus cycles outside the program window do not advance the stream, so the CPU's own data reads and writes pass through untouched. Program RAM is disabled on every cycle that the block answers. The generated stream moves the CPU program counter forward through the program window, so software must place the trigger store where the counter cannot wrap past the top of memory.

Top module: `unroll_copy_gen`

## Requirements
- R1: After reset the block is idle (`busy` low), never drives `cpu_rdata_oe`, holds `cpu_rdata` at zero, and `prg_ram_en` is high exactly when `cpu_addr` lies in the program window (default $8000 to $FFFF).
- R2: Write cycles to the register base (default $5000) set the byte registers at these offsets: +0 length high, +1 length low, +2 source high, +3 source low. A write to +4 starts a transfer to the video data port ($2007). A write to +5 starts a transfer to the sprite data port ($2004).
- R3: A trigger write while idle raises `busy` on the next clock. The address of the first program-window read that follows is saved as the resume address.
- R4: Each moved byte is fed as six bytes in this order: $AD, source low, source high, $8D, port low, port high. The source pointer starts at the programmed value, rises by one per pair, and carries from low byte into high byte.
- R5: The number of load/store pairs equals the programmed length plus one (length $01FF gives 512 pairs).
- R6: After the last pair the block feeds $4C, resume low, resume high. `busy` falls on the clock after the third jump byte is taken.
- R7: The block drives the data bus only while busy, on read cycles inside the program window, and `prg_ram_en` is low exactly on those cycles. Reads outside the window and all write cycles neither get driven nor advance the stream.
- R8: While busy, writes to the length, source and trigger registers are ignored. The registers keep their values after a transfer, so a repeated trigger repeats the same copy.
- R9: The port in the store operands is $2007 for a +4 trigger and $2004 for a +5 trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | Data written by the CPU |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_stb | input | 1 | One-clock pulse marking the end of a CPU bus cycle |
| cpu_rdata | output | 8 | Generated instruction byte (zero when not driving) |
| cpu_rdata_oe | output | 1 | High while the block drives the data bus |
| prg_ram_en | output | 1 | Program RAM enable, low while the block answers |
| busy | output | 1 | Instruction stream in progress |

## Verification
The assertions take for granted that the CPU consumes the fed bytes the way the processor does. Every program-window read during a transfer is an instruction-stream fetch, and each bus cycle brings exactly one `cpu_stb` pulse. The bench keeps to this by emulating a CPU core that decodes the fed opcodes: it fetches operands, performs the load's data read outside the window, and performs the store as a write. It inserts foreign traffic only as out-of-window reads and writes, or as ignored register and trigger writes between generated instructions.

// File: rtl/ucg_pkg.sv
package ucg_pkg;

   localparam logic [7:0] OP_LOAD_ABS  = 8'hAD;
   localparam logic [7:0] OP_STORE_ABS = 8'h8D;
   localparam logic [7:0] OP_JUMP_ABS  = 8'h4C;

   localparam int PAIR_LEN = 6;
   localparam int JUMP_LEN = 3;

   typedef enum logic [1:0] {
      SEG_IDLE,
      SEG_PAIR,
      SEG_JUMP
   } seg_t;

   typedef enum logic [2:0] {
      SL_LD_OPC  = 3'd0,
      SL_SRC_LO  = 3'd1,
      SL_SRC_HI  = 3'd2,
      SL_ST_OPC  = 3'd3,
      SL_PORT_LO = 3'd4,
      SL_PORT_HI = 3'd5
   } slot_t;

endpackage

// File: rtl/ucg_regs.sv
module ucg_regs #(
   parameter int                ADDR_W   = 16,
   parameter int                DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG_BASE = 16'h5000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                lock,
   output logic [2*DATA_W-1:0] len_q,
   output logic [2*DATA_W-1:0] src_q,
   output logic                go_video,
   output logic                go_sprite
);

   localparam int NUM_BYTES = 4;
   localparam logic [ADDR_W-1:0] TRIG_VIDEO  = REG_BASE + ADDR_W'(NUM_BYTES);
   localparam logic [ADDR_W-1:0] TRIG_SPRITE = REG_BASE + ADDR_W'(NUM_BYTES + 1);

   logic open_wr;
   assign open_wr = wr_stb && !lock;

   // byte registers, offset order: len hi, len lo, src hi, src lo
   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      localparam logic [ADDR_W-1:0] MY_ADDR = REG_BASE + ADDR_W'(i);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (open_wr && addr == MY_ADDR)
            q <= wdata;
      end
   end

   assign len_q     = {g_byte[0].q, g_byte[1].q};
   assign src_q     = {g_byte[2].q, g_byte[3].q};
   assign go_video  = open_wr && (addr == TRIG_VIDEO);
   assign go_sprite = open_wr && (addr == TRIG_SPRITE);

   // R8: programmed values do not move while a transfer runs
   p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(len_q) && $stable(src_q)));

endmodule

// File: rtl/ucg_seq.sv
module ucg_seq
   import ucg_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_video,
   input  logic              go_sprite,
   input  logic [CNT_W-1:0]  len_in,
   input  logic [ADDR_W-1:0] src_in,
   input  logic              adv,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              busy,
   output seg_t              seg,
   output slot_t             slot,
   output logic [1:0]        jidx,
   output logic [ADDR_W-1:0] src_cur,
   output logic [ADDR_W-1:0] resume,
   output logic              to_sprite
);

   localparam logic [1:0] JIDX_LAST = 2'(JUMP_LEN - 1);

   logic              busy_q, res_pend_q, spr_q;
   seg_t              seg_q;
   slot_t             slot_q;
   logic [1:0]        jidx_q;
   logic [CNT_W-1:0]  left_q;
   logic [ADDR_W-1:0] src_q, res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         res_pend_q <= 1'b0;
         spr_q      <= 1'b0;
         seg_q      <= SEG_IDLE;
         slot_q     <= SL_LD_OPC;
         jidx_q     <= '0;
         left_q     <= '0;
         src_q      <= '0;
         res_q      <= '0;
      end else if (!busy_q) begin
         if (go_video || go_sprite) begin
            busy_q     <= 1'b1;
            res_pend_q <= 1'b1;
            spr_q      <= go_sprite;
            seg_q      <= SEG_PAIR;
            slot_q     <= SL_LD_OPC;
            jidx_q     <= '0;
            left_q     <= len_in;
            src_q      <= src_in;
         end
      end else if (adv) begin
         if (res_pend_q) begin
            res_q      <= fetch_addr;
            res_pend_q <= 1'b0;
         end
         case (seg_q)
            SEG_PAIR: begin
               if (slot_q == SL_PORT_HI) begin
                  slot_q <= SL_LD_OPC;
                  if (left_q == '0) begin
                     seg_q  <= SEG_JUMP;
                     jidx_q <= '0;
                  end else begin
                     left_q <= left_q - CNT_W'(1);
                     src_q  <= src_q + ADDR_W'(1);
                  end
               end else begin
                  slot_q <= slot_t'(slot_q + 3'd1);
               end
            end
            SEG_JUMP: begin
               if (jidx_q == JIDX_LAST) begin
                  busy_q <= 1'b0;
                  seg_q  <= SEG_IDLE;
               end else begin
                  jidx_q <= jidx_q + 2'd1;
               end
            end
            default: seg_q <= SEG_IDLE;
         endcase
      end
   end

   assign busy      = busy_q;
   assign seg       = seg_q;
   assign slot      = slot_q;
   assign jidx      = jidx_q;
   assign src_cur   = src_q;
   assign resume    = res_q;
   assign to_sprite = spr_q;

   // R3: a new transfer opens on a load opcode, waiting for its resume address
   p_start_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (seg_q == SEG_PAIR && slot_q == SL_LD_OPC && res_pend_q));

   // R4: the source pointer steps by one between consecutive pairs
   p_src_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy_q && seg_q == SEG_PAIR && slot_q == SL_PORT_HI && adv) && seg_q == SEG_PAIR)
      |-> (src_q == $past(src_q) + ADDR_W'(1)));

   // R5: the remaining-pair count never rises within one transfer
   p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> (left_q <= $past(left_q)));

   // R6: busy drops only after the final jump byte was taken
   p_end_after_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(seg_q == SEG_JUMP && jidx_q == JIDX_LAST && adv));

endmodule

// File: rtl/ucg_feed_mux.sv
module ucg_feed_mux
   import ucg_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] VIDEO_PORT  = 16'h2007,
   parameter logic [ADDR_W-1:0] SPRITE_PORT = 16'h2004
) (
   input  seg_t              seg,
   input  slot_t             slot,
   input  logic [1:0]        jidx,
   input  logic [ADDR_W-1:0] src_cur,
   input  logic [ADDR_W-1:0] resume,
   input  logic              to_sprite,
   output logic [DATA_W-1:0] feed_byte
);

   logic [ADDR_W-1:0] port;
   assign port = to_sprite ? SPRITE_PORT : VIDEO_PORT;

   always_comb begin
      feed_byte = '0;
      case (seg)
         SEG_PAIR: begin
            case (slot)
               SL_LD_OPC:  feed_byte = OP_LOAD_ABS;
               SL_SRC_LO:  feed_byte = src_cur[DATA_W-1:0];
               SL_SRC_HI:  feed_byte = src_cur[ADDR_W-1:DATA_W];
               SL_ST_OPC:  feed_byte = OP_STORE_ABS;
               SL_PORT_LO: feed_byte = port[DATA_W-1:0];
               SL_PORT_HI: feed_byte = port[ADDR_W-1:DATA_W];
               default:    feed_byte = '0;
            endcase
         end
         SEG_JUMP: begin
            case (jidx)
               2'd0:    feed_byte = OP_JUMP_ABS;
               2'd1:    feed_byte = resume[DATA_W-1:0];
               2'd2:    feed_byte = resume[ADDR_W-1:DATA_W];
               default: feed_byte = '0;
            endcase
         end
         default: feed_byte = '0;
      endcase
   end

endmodule

// File: rtl/unroll_copy_gen.sv
module unroll_copy_gen
   import ucg_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] REG_BASE    = 16'h5000,
   parameter logic [ADDR_W-1:0] WIN_LO      = 16'h8000,
   parameter logic [ADDR_W-1:0] WIN_HI      = 16'hFFFF,
   parameter logic [ADDR_W-1:0] VIDEO_PORT  = 16'h2007,
   parameter logic [ADDR_W-1:0] SPRITE_PORT = 16'h2004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_rw,
   input  logic              cpu_stb,
   output logic [7:0]        cpu_rdata,
   output logic              cpu_rdata_oe,
   output logic              prg_ram_en,
   output logic              busy
);

   localparam int CNT_W = 2 * DATA_W;

   // elaboration-time parameter checks
   if (ADDR_W != 16) begin : g_bad_addr
      $error("unroll_copy_gen: absolute operands need ADDR_W of 16");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("unroll_copy_gen: opcode bytes need DATA_W of 8");
   end
   if (WIN_HI < WIN_LO) begin : g_bad_win
      $error("unroll_copy_gen: program window is empty");
   end
   if (VIDEO_PORT == SPRITE_PORT) begin : g_bad_port
      $error("unroll_copy_gen: the two target ports must differ");
   end
   if (REG_BASE + ADDR_W'(5) >= WIN_LO && REG_BASE <= WIN_HI) begin : g_bad_regs
      $error("unroll_copy_gen: registers overlap the program window");
   end

   logic in_win;
   if (WIN_HI == {ADDR_W{1'b1}}) begin : g_win_top
      assign in_win = (cpu_addr >= WIN_LO);
   end else begin : g_win_range
      assign in_win = (cpu_addr >= WIN_LO) && (cpu_addr <= WIN_HI);
   end

   logic              busy_w, feed, adv, go_v, go_s, spr_w;
   logic [CNT_W-1:0]  len_w;
   logic [ADDR_W-1:0] src_w, src_cur_w, resume_w;
   logic [DATA_W-1:0] byte_w;
   logic [1:0]        jidx_w;
   seg_t              seg_w;
   slot_t             slot_w;

   assign feed = busy_w && cpu_rw && in_win;
   assign adv  = feed && cpu_stb;

   ucg_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_BASE (REG_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (cpu_stb && !cpu_rw),
      .addr      (cpu_addr),
      .wdata     (cpu_wdata),
      .lock      (busy_w),
      .len_q     (len_w),
      .src_q     (src_w),
      .go_video  (go_v),
      .go_sprite (go_s)
   );

   ucg_seq #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_video   (go_v),
      .go_sprite  (go_s),
      .len_in     (len_w),
      .src_in     (src_w),
      .adv        (adv),
      .fetch_addr (cpu_addr),
      .busy       (busy_w),
      .seg        (seg_w),
      .slot       (slot_w),
      .jidx       (jidx_w),
      .src_cur    (src_cur_w),
      .resume     (resume_w),
      .to_sprite  (spr_w)
   );

   ucg_feed_mux #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .VIDEO_PORT  (VIDEO_PORT),
      .SPRITE_PORT (SPRITE_PORT)
   ) u_mux (
      .seg       (seg_w),
      .slot      (slot_w),
      .jidx      (jidx_w),
      .src_cur   (src_cur_w),
      .resume    (resume_w),
      .to_sprite (spr_w),
      .feed_byte (byte_w)
   );

   assign cpu_rdata    = feed ? byte_w : '0;
   assign cpu_rdata_oe = feed;
   assign prg_ram_en   = in_win && !feed;
   assign busy         = busy_w;

   // R7: the bus is driven only on read cycles of a running transfer
   p_drive_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdata_oe |-> (cpu_rw && busy));

   // R7: program RAM and the generator never answer the same cycle
   p_prg_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdata_oe |-> !prg_ram_en);

   // R1: an idle block leaves the data bus quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!cpu_rdata_oe && cpu_rdata == 8'h00));

   // R3: a trigger taken while idle opens a transfer on the next clock
   p_trigger_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cpu_stb && !cpu_rw &&
       (cpu_addr == REG_BASE + 16'd4 || cpu_addr == REG_BASE + 16'd5)) |=> busy);

endmodule

// File: tb/unroll_copy_gen_test.sv
`timescale 1ns/1ps
module unroll_copy_gen_test;

   localparam logic [15:0] REGB  = 16'h5000;
   localparam logic [15:0] VPORT = 16'h2007;
   localparam logic [15:0] SPORT = 16'h2004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_wdata = 8'h00;
   logic        cpu_rw = 1'b1;
   logic        cpu_stb = 1'b0;
   logic [7:0]  cpu_rdata;
   logic        cpu_rdata_oe, prg_ram_en, busy;

   always #2 clk = ~clk;

   unroll_copy_gen uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_addr     (cpu_addr),
      .cpu_wdata    (cpu_wdata),
      .cpu_rw       (cpu_rw),
      .cpu_stb      (cpu_stb),
      .cpu_rdata    (cpu_rdata),
      .cpu_rdata_oe (cpu_rdata_oe),
      .prg_ram_en   (prg_ram_en),
      .busy         (busy)
   );

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural reference model
   logic [7:0] exp_q[$];
   logic [7:0] m_reg [4];
   bit         m_busy = 0;
   bit         m_need_res = 0;

   initial for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;

   function automatic logic [7:0] rom(input logic [15:0] a);
      return a[7:0] ^ 8'hA5;
   endfunction

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_start(input logic [15:0] port);
      logic [15:0] len, src;
      len = {m_reg[0], m_reg[1]};
      src = {m_reg[2], m_reg[3]};
      for (int k = 0; k <= int'(len); k++) begin
         logic [15:0] s;
         s = src + 16'(k);
         exp_q.push_back(8'hAD);
         exp_q.push_back(s[7:0]);
         exp_q.push_back(s[15:8]);
         exp_q.push_back(8'h8D);
         exp_q.push_back(port[7:0]);
         exp_q.push_back(port[15:8]);
      end
      m_busy = 1;
      m_need_res = 1;
   endtask

   task automatic model_step(input logic [15:0] a, input bit rw, input logic [7:0] d);
      if (!rw) begin
         if (!m_busy) begin
            if (a >= REGB && a <= REGB + 16'd3) m_reg[a[1:0]] = d;
            else if (a == REGB + 16'd4) model_start(VPORT);
            else if (a == REGB + 16'd5) model_start(SPORT);
         end
      end else if (m_busy && a >= 16'h8000) begin
         if (m_need_res) begin
            exp_q.push_back(8'h4C);
            exp_q.push_back(a[7:0]);
            exp_q.push_back(a[15:8]);
            m_need_res = 0;
         end
         void'(exp_q.pop_front());
         if (exp_q.size() == 0) m_busy = 0;
      end
   endtask

   // per-clock comparison against the model
   task automatic compare(input logic [15:0] a, input bit rw);
      bit         e_oe, e_prg;
      logic [7:0] e_d;
      e_oe  = m_busy && rw && (a >= 16'h8000);
      e_prg = (a >= 16'h8000) && !e_oe;
      e_d   = e_oe ? exp_q[0] : 8'h00;
      n_checks++;
      if (cpu_rdata_oe !== e_oe || prg_ram_en !== e_prg) begin
         n_fail++;
         $display("FAIL R7 oe/prg actual %b/%b expected %b/%b addr %h",
                  cpu_rdata_oe, prg_ram_en, e_oe, e_prg, a);
      end else if (cpu_rdata !== e_d) begin
         n_fail++;
         $display("FAIL R4 R6 fed byte actual %h expected %h addr %h", cpu_rdata, e_d, a);
      end else if (busy !== m_busy) begin
         n_fail++;
         $display("FAIL R3 busy actual %b expected %b", busy, m_busy);
      end
   endtask

   // one CPU bus cycle: strobe clock, then a quiet clock
   task automatic bus(input logic [15:0] a, input bit rw, input logic [7:0] d,
                      output logic [7:0] rd);
      @(negedge clk);
      cpu_addr = a; cpu_rw = rw; cpu_wdata = d; cpu_stb = 1'b1;
      #1;
      compare(a, rw);
      rd = cpu_rdata_oe ? cpu_rdata : rom(a);
      model_step(a, rw, d);
      @(negedge clk);
      cpu_stb = 1'b0;
      #1;
      compare(a, rw);
   endtask

   task automatic wr_reg(input int ofs, input logic [7:0] v);
      logic [7:0] rd;
      bus(REGB + 16'(ofs), 1'b0, v, rd);
   endtask

   // emulated store to a trigger register at pc; returns the resume point
   task automatic trigger(input logic [15:0] pc, input int ofs, output logic [15:0] res);
      logic [7:0] rd;
      bus(pc, 1'b1, 0, rd);
      bus(pc + 16'd1, 1'b1, 0, rd);
      bus(pc + 16'd2, 1'b1, 0, rd);
      bus(REGB + 16'(ofs), 1'b0, 8'h00, rd);
      res = pc + 16'd3;
   endtask

   // CPU core executing the fed stream; disturb_at < 0 means no foreign traffic
   task automatic run_stream(input logic [15:0] pc0, input logic [15:0] port,
                             input logic [15:0] src0, input int npairs,
                             input int disturb_at);
      logic [15:0] pc, src_exp;
      logic [7:0]  op, lo, hi, rd;
      int          copied, insn;
      bit          done;
      pc = pc0; src_exp = src0; copied = 0; insn = 0; done = 0;
      for (int guard = 0; guard < 140000 && !done; guard++) begin
         if (insn == disturb_at) begin
            bus(REGB + 16'd1, 1'b0, 8'h77, rd);
            bus(REGB + 16'd4, 1'b0, 8'h00, rd);
            bus(REGB + 16'd5, 1'b0, 8'h00, rd);
            bus(16'h0100, 1'b1, 0, rd);
            bus(16'h01FF, 1'b0, 8'h3C, rd);
         end
         bus(pc, 1'b1, 0, op); pc++;
         bus(pc, 1'b1, 0, lo); pc++;
         bus(pc, 1'b1, 0, hi); pc++;
         insn++;
         case (op)
            8'hAD: begin
               check({hi, lo} == src_exp, "R4", "load operand", {hi, lo}, src_exp);
               bus({hi, lo}, 1'b1, 0, rd);
               src_exp++;
            end
            8'h8D: begin
               check({hi, lo} == port, "R9", "store operand", {hi, lo}, port);
               bus({hi, lo}, 1'b0, 8'h11, rd);
               copied++;
            end
            8'h4C: begin
               check({hi, lo} == pc0, "R6", "jump target", {hi, lo}, pc0);
               check(copied == npairs, "R5", "pair count", copied, npairs);
               done = 1;
            end
            default: begin
               check(1'b0, "R4", "unexpected opcode", op, 8'hAD);
               done = 1;
            end
         endcase
      end
      check(busy == 1'b0, "R6", "busy after jump", busy, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      report();
      $finish;
   end

   initial begin
      logic [15:0] res;
      logic [7:0]  rd;

      // R1: outputs during and after reset
      repeat (3) @(negedge clk);
      cpu_addr = 16'h8123;
      #1;
      check(cpu_rdata_oe == 1'b0 && busy == 1'b0, "R1", "idle in reset", {busy, cpu_rdata_oe}, 0);
      check(prg_ram_en == 1'b1, "R1", "prg enable in window", prg_ram_en, 1);
      rst_n = 1'b1;
      bus(16'h8123, 1'b1, 0, rd);
      check(rd == rom(16'h8123) && cpu_rdata == 8'h00, "R1", "idle read not driven", rd, rom(16'h8123));
      bus(16'h0200, 1'b1, 0, rd);
      check(prg_ram_en == 1'b0, "R1", "prg enable outside window", prg_ram_en, 0);

      // R2 R5: single-pair transfer, length 0
      wr_reg(0, 8'h00); wr_reg(1, 8'h00); wr_reg(2, 8'h03); wr_reg(3, 8'h00);
      trigger(16'hC000, 4, res);
      check(busy == 1'b1, "R3", "busy after trigger", busy, 1);
      run_stream(res, VPORT, 16'h0300, 1, -1);

      // R4: source carry across a page
      wr_reg(0, 8'h00); wr_reg(1, 8'h03); wr_reg(2, 8'h04); wr_reg(3, 8'hFE);
      trigger(16'hC100, 4, res);
      run_stream(res, VPORT, 16'h04FE, 4, -1);

      // R5: length $01FF from $0300 gives 512 pairs
      wr_reg(0, 8'h01); wr_reg(1, 8'hFF); wr_reg(2, 8'h03); wr_reg(3, 8'h00);
      trigger(16'h9000, 4, res);
      run_stream(res, VPORT, 16'h0300, 512, -1);

      // R9: sprite port trigger
      wr_reg(0, 8'h00); wr_reg(1, 8'h02); wr_reg(2, 8'h02); wr_reg(3, 8'h00);
      trigger(16'hD000, 5, res);
      run_stream(res, SPORT, 16'h0200, 3, -1);

      // R7 R8: foreign traffic and ignored writes mid-stream
      wr_reg(0, 8'h00); wr_reg(1, 8'h05); wr_reg(2, 8'h06); wr_reg(3, 8'h00);
      trigger(16'hE000, 4, res);
      run_stream(res, VPORT, 16'h0600, 6, 3);

      // R8: registers kept, repeat trigger repeats the same copy
      trigger(16'hE800, 4, res);
      run_stream(res, VPORT, 16'h0600, 6, -1);

      report();
      $finish;
   end

endmodule